// File: doc/BRIEF.md
# DMA Handshake Ready Generator for a Serial Port

This block produces the two active-low request lines that a DMA controller watches to move characters in and out of a serial port: one asks for transmit data (`tx_rdy_n`), the other announces receive data (`rx_rdy_n`). It does not hold any data. It reads the current fill counts of the transmit and receive queues, together with the queue enable and a mode select. From these it decides, once per clock, whether each request line should be asserted.

Two handshake styles are offered. In single-character mode the lines only tell empty from not-empty. In burst mode they compare the queue occupancy against thresholds, which are picked by two 2-bit selector fields. In burst mode the receive line also has hysteresis: it is raised by reaching the threshold and dropped only when the queue drains completely. The threshold tables, the queue depth and the hysteresis variant are parameters.

Top module: `dma_rdy_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after its release, both `tx_rdy_n` and `rx_rdy_n` are 1 (inactive).
- R2: Burst mode is in force when `q_en` and `burst_sel` are both 1. Otherwise single-character mode is used. A change of either input takes effect on the output registered at the next rising clock edge.
- R3: In single-character mode, `tx_rdy_n` is 0 when the transmit count sampled at the previous edge was 0, and 1 otherwise.
- R4: In single-character mode, `rx_rdy_n` is 0 when the receive count sampled at the previous edge was non-zero, and 1 when it was 0.
- R5: In burst mode, `tx_rdy_n` is 0 exactly when the transmit count is below the transmit threshold. `tx_lvl_sel` codes 0,1,2,3 select thresholds 16, 8, 24 and 30.
- R6: In burst mode, `rx_rdy_n` becomes 0 when the receive count is at or above the receive threshold. `rx_lvl_sel` codes 0,1,2,3 select thresholds 8, 16, 24 and 28.
- R7: In burst mode, once the receive request is active it stays 0 while the receive count is non-zero, even when the count is below the threshold. It returns to 1 on the edge after the count is 0.
- R8: With `q_en` at 0, `burst_sel` has no effect: both lines follow the single-character rules.
- R9: The receive hysteresis state is kept in both modes. It is set when count ≥ threshold, cleared when count is 0, and otherwise held. After a switch to burst mode, a receive count that is non-zero but below the threshold gives `rx_rdy_n` = 0 only if the threshold was reached since the last empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_en | input | 1 | Queues enabled |
| burst_sel | input | 1 | 1 selects burst (threshold) handshake |
| tx_lvl_sel | input | 2 | Transmit threshold selector |
| rx_lvl_sel | input | 2 | Receive threshold selector |
| tx_count | input | 6 | Characters held in the transmit queue (0..32) |
| rx_count | input | 6 | Characters held in the receive queue (0..32) |
| tx_rdy_n | output | 1 | Transmit data request, active low |
| rx_rdy_n | output | 1 | Receive data request, active low |

## Verification
The only hidden state is the receive hysteresis flag. A wrong value of it shows up at `rx_rdy_n` only in burst mode, and only while the receive count sits strictly between zero and the threshold. It then appears on the very next clock. The stimulus therefore walks the receive count slowly up through the threshold and back down, and switches modes in the middle of such walks. A wrong threshold decode shows at the next edge once a count lands exactly on, or one below, the selected level. Directed cases place counts there for every selector code.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;
   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_BURST  = 1'b1
   } dma_mode_e;

   function automatic int unsigned cnt_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/dma_rdy_mode_sel.sv
module dma_rdy_mode_sel
   import dma_rdy_pkg::*;
(
   input  logic      q_en,
   input  logic      burst_sel,
   output dma_mode_e mode
);
   always_comb begin
      mode = (q_en && burst_sel) ? MODE_BURST : MODE_SINGLE;
   end
endmodule

// File: rtl/dma_rdy_lvl_dec.sv
module dma_rdy_lvl_dec #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CNT_W = 6,
   parameter int unsigned LVL0  = 8,
   parameter int unsigned LVL1  = 16,
   parameter int unsigned LVL2  = 24,
   parameter int unsigned LVL3  = 28
) (
   input  logic [1:0]       sel,
   output logic [CNT_W-1:0] level
);
   localparam int unsigned MAX_LVL = (1 << CNT_W) - 1;

   generate
      if (LVL0 == 0 || LVL0 > DEPTH) begin : g_bad0
         $error("threshold 0 outside 1..DEPTH");
      end
      if (LVL1 == 0 || LVL1 > DEPTH) begin : g_bad1
         $error("threshold 1 outside 1..DEPTH");
      end
      if (LVL2 == 0 || LVL2 > DEPTH) begin : g_bad2
         $error("threshold 2 outside 1..DEPTH");
      end
      if (LVL3 == 0 || LVL3 > DEPTH) begin : g_bad3
         $error("threshold 3 outside 1..DEPTH");
      end
      if (DEPTH > MAX_LVL) begin : g_badw
         $error("count width too narrow for DEPTH");
      end
   endgenerate

   always_comb begin
      unique case (sel)
         2'd0:    level = CNT_W'(LVL0);
         2'd1:    level = CNT_W'(LVL1);
         2'd2:    level = CNT_W'(LVL2);
         default: level = CNT_W'(LVL3);
      endcase
   end
endmodule

// File: rtl/dma_rdy_tx_gen.sv
module dma_rdy_tx_gen
   import dma_rdy_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dma_mode_e        mode,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] level,
   output logic             tx_rdy_n
);
   logic below_lvl;
   logic is_empty;

   always_comb begin
      below_lvl = (count < level);
      is_empty  = (count == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_rdy_n <= 1'b1;
      end else if (mode == MODE_BURST) begin
         tx_rdy_n <= !below_lvl;
      end else begin
         tx_rdy_n <= !is_empty;
      end
   end

   AST_TX_SINGLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SINGLE && count == '0) |=> !tx_rdy_n); // R3
   AST_TX_SINGLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SINGLE && count != '0) |=> tx_rdy_n); // R3
   AST_TX_BURST_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_BURST && count < level) |=> !tx_rdy_n); // R5
   AST_TX_BURST_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_BURST && count >= level) |=> tx_rdy_n); // R5
endmodule

// File: rtl/dma_rdy_rx_gen.sv
module dma_rdy_rx_gen
   import dma_rdy_pkg::*;
#(
   parameter int unsigned CNT_W   = 6,
   parameter bit          HYST_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dma_mode_e        mode,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] level,
   output logic             rx_rdy_n
);
   logic is_empty;
   logic lvl_hit;
   logic burst_act;

   always_comb begin
      is_empty = (count == '0);
      lvl_hit  = (count >= level);
   end

   generate
      if (HYST_EN) begin : g_hyst
         logic armed_q;
         logic armed_d;

         always_comb begin
            if (is_empty) begin
               armed_d = 1'b0;
            end else if (lvl_hit) begin
               armed_d = 1'b1;
            end else begin
               armed_d = armed_q;
            end
            burst_act = armed_d;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed_q <= 1'b0;
            end else begin
               armed_q <= armed_d;
            end
         end

         AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_BURST && armed_q && count != '0) |=> !rx_rdy_n); // R7
      end else begin : g_plain
         always_comb begin
            burst_act = lvl_hit;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_rdy_n <= 1'b1;
      end else if (mode == MODE_BURST) begin
         rx_rdy_n <= !burst_act;
      end else begin
         rx_rdy_n <= is_empty;
      end
   end

   AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SINGLE) |=> (rx_rdy_n == $past(count == '0))); // R4
   AST_RX_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |=> rx_rdy_n); // R7
   AST_RX_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_BURST && count >= level && count != '0) |=> !rx_rdy_n); // R6
endmodule

// File: rtl/dma_rdy_gen.sv
module dma_rdy_gen
   import dma_rdy_pkg::*;
#(
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned RX_LVL_0 = 8,
   parameter int unsigned RX_LVL_1 = 16,
   parameter int unsigned RX_LVL_2 = 24,
   parameter int unsigned RX_LVL_3 = 28,
   parameter int unsigned TX_LVL_0 = 16,
   parameter int unsigned TX_LVL_1 = 8,
   parameter int unsigned TX_LVL_2 = 24,
   parameter int unsigned TX_LVL_3 = 30,
   parameter bit          HYST_EN  = 1'b1,
   localparam int unsigned CNT_W   = cnt_width(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             q_en,
   input  logic             burst_sel,
   input  logic [1:0]       tx_lvl_sel,
   input  logic [1:0]       rx_lvl_sel,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   output logic             tx_rdy_n,
   output logic             rx_rdy_n
);
   dma_mode_e        mode;
   logic [CNT_W-1:0] tx_level;
   logic [CNT_W-1:0] rx_level;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   dma_rdy_mode_sel u_mode (
      .q_en      (q_en),
      .burst_sel (burst_sel),
      .mode      (mode)
   );

   dma_rdy_lvl_dec #(
      .DEPTH (DEPTH), .CNT_W (CNT_W),
      .LVL0 (TX_LVL_0), .LVL1 (TX_LVL_1), .LVL2 (TX_LVL_2), .LVL3 (TX_LVL_3)
   ) u_tx_lvl (
      .sel   (tx_lvl_sel),
      .level (tx_level)
   );

   dma_rdy_lvl_dec #(
      .DEPTH (DEPTH), .CNT_W (CNT_W),
      .LVL0 (RX_LVL_0), .LVL1 (RX_LVL_1), .LVL2 (RX_LVL_2), .LVL3 (RX_LVL_3)
   ) u_rx_lvl (
      .sel   (rx_lvl_sel),
      .level (rx_level)
   );

   dma_rdy_tx_gen #(.CNT_W (CNT_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .count    (tx_count),
      .level    (tx_level),
      .tx_rdy_n (tx_rdy_n)
   );

   dma_rdy_rx_gen #(.CNT_W (CNT_W), .HYST_EN (HYST_EN)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .count    (rx_count),
      .level    (rx_level),
      .rx_rdy_n (rx_rdy_n)
   );

   AST_Q_OFF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_en) |=> (tx_rdy_n == ($past(tx_count) != '0))); // R8
endmodule

// File: tb/dma_rdy_gen_tb.sv
module dma_rdy_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       q_en = 1'b0;
   logic       burst_sel = 1'b0;
   logic [1:0] tx_lvl_sel = 2'd0;
   logic [1:0] rx_lvl_sel = 2'd0;
   logic [5:0] tx_count = 6'd0;
   logic [5:0] rx_count = 6'd0;
   logic       tx_rdy_n;
   logic       rx_rdy_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   bit m_armed = 1'b0;
   bit m_tx = 1'b1;
   bit m_rx = 1'b1;

   always #4 clk = ~clk;

   dma_rdy_gen dut_i (
      .clk (clk), .rst_n (rst_n), .q_en (q_en), .burst_sel (burst_sel),
      .tx_lvl_sel (tx_lvl_sel), .rx_lvl_sel (rx_lvl_sel),
      .tx_count (tx_count), .rx_count (rx_count),
      .tx_rdy_n (tx_rdy_n), .rx_rdy_n (rx_rdy_n)
   );

   function automatic int rx_thr(input logic [1:0] c);
      case (c)
         2'd0: return 8;
         2'd1: return 16;
         2'd2: return 24;
         default: return 28;
      endcase
   endfunction

   function automatic int tx_thr(input logic [1:0] c);
      case (c)
         2'd0: return 16;
         2'd1: return 8;
         2'd2: return 24;
         default: return 30;
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Model of one rising edge, from the requirements
   task automatic model_edge();
      bit burst;
      bit nxt;
      burst = q_en && burst_sel;
      if (rx_count == 0) nxt = 1'b0;
      else if (rx_count >= rx_thr(rx_lvl_sel)) nxt = 1'b1;
      else nxt = m_armed;
      m_armed = nxt;
      if (burst) begin
         m_tx = !(tx_count < tx_thr(tx_lvl_sel));
         m_rx = !nxt;
      end else begin
         m_tx = (tx_count != 0);
         m_rx = (rx_count == 0);
      end
   endtask

   task automatic step(input string rtx, input string rrx);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(rtx, tx_rdy_n, m_tx);
      check(rrx, rx_rdy_n, m_rx);
   endtask

   task automatic drive(input bit en, input bit b, input logic [1:0] ts,
                        input logic [1:0] rs, input int tc, input int rc);
      q_en = en; burst_sel = b; tx_lvl_sel = ts; rx_lvl_sel = rs;
      tx_count = 6'(tc); rx_count = 6'(rc);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      int rc;
      int tc;
      void'($urandom(32'd1234));
      drive(1, 1, 2'd0, 2'd0, 0, 5);
      repeat (3) @(negedge clk);
      check("R1 tx in reset", tx_rdy_n, 1'b1);
      check("R1 rx in reset", rx_rdy_n, 1'b1);
      rst_n = 1'b1;
      drive(1, 1, 2'd0, 2'd0, 20, 0);
      step("R1 tx after reset", "R1 rx after reset");
      check("R1 tx first edge", tx_rdy_n, 1'b1);
      check("R1 rx first edge", rx_rdy_n, 1'b1);

      // R3 / R4 single-character mode
      drive(1, 0, 2'd0, 2'd0, 0, 0);  step("R3 tx empty", "R4 rx empty");
      check("R3 tx empty low", tx_rdy_n, 1'b0);
      drive(1, 0, 2'd0, 2'd0, 1, 1);  step("R3 tx one char", "R4 rx one char");
      check("R4 rx one char low", rx_rdy_n, 1'b0);
      drive(1, 0, 2'd3, 2'd3, 32, 32); step("R3 tx full", "R4 rx full");

      // R5 / R6 every code at and below its threshold
      for (int c = 0; c < 4; c++) begin
         drive(1, 1, 2'(c), 2'(c), tx_thr(2'(c)) - 1, 0);
         step("R5 tx below threshold", "R7 rx empty");
         check("R5 tx below low", tx_rdy_n, 1'b0);
         drive(1, 1, 2'(c), 2'(c), tx_thr(2'(c)), rx_thr(2'(c)) - 1);
         step("R5 tx at threshold", "R6 rx below threshold");
         check("R6 rx below high", rx_rdy_n, 1'b1);
         drive(1, 1, 2'(c), 2'(c), tx_thr(2'(c)), rx_thr(2'(c)));
         step("R5 tx at threshold", "R6 rx at threshold");
         check("R6 rx at threshold low", rx_rdy_n, 1'b0);
         // R7: falls below but non-empty keeps request
         drive(1, 1, 2'(c), 2'(c), 0, 1);
         step("R5 tx empty", "R7 rx held above zero");
         check("R7 rx held", rx_rdy_n, 1'b0);
         drive(1, 1, 2'(c), 2'(c), 0, 0);
         step("R5 tx empty", "R7 rx drained");
         check("R7 rx drained high", rx_rdy_n, 1'b1);
      end

      // R8: queues off, burst bit ignored
      drive(0, 1, 2'd3, 2'd0, 20, 4);
      step("R8 tx queues off", "R8 rx queues off");
      check("R8 tx not burst", tx_rdy_n, 1'b1);
      check("R8 rx not burst", rx_rdy_n, 1'b0);

      // R9 / R2: hysteresis kept in single mode, seen after switch
      drive(1, 0, 2'd0, 2'd0, 5, 20); step("R2 tx", "R9 rx arm in single");
      drive(1, 0, 2'd0, 2'd0, 5, 4);  step("R2 tx", "R9 rx single below");
      drive(1, 1, 2'd0, 2'd0, 5, 4);  step("R2 tx switch", "R9 rx armed after switch");
      check("R9 rx armed after switch", rx_rdy_n, 1'b0);
      check("R2 tx burst next edge", tx_rdy_n, 1'b0);
      drive(1, 0, 2'd0, 2'd0, 5, 0);  step("R2 tx", "R9 rx clear in single");
      drive(1, 0, 2'd0, 2'd0, 5, 4);  step("R2 tx", "R9 rx single");
      drive(1, 1, 2'd0, 2'd0, 5, 4);  step("R2 tx switch", "R9 rx unarmed after switch");
      check("R9 rx unarmed high", rx_rdy_n, 1'b1);

      // random walk
      rc = 0; tc = 0;
      for (int i = 0; i < 3000; i++) begin
         string rt;
         string rr;
         rc = rc + int'($urandom_range(0, 6)) - 3;
         tc = tc + int'($urandom_range(0, 8)) - 4;
         if (rc < 0) rc = 0;
         if (rc > 32) rc = 32;
         if (tc < 0) tc = 0;
         if (tc > 32) tc = 32;
         if ($urandom_range(0, 31) == 0) q_en = ~q_en;
         if ($urandom_range(0, 15) == 0) burst_sel = ~burst_sel;
         if ($urandom_range(0, 63) == 0) tx_lvl_sel = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 63) == 0) rx_lvl_sel = 2'($urandom_range(0, 3));
         tx_count = 6'(tc);
         rx_count = 6'(rc);
         if (q_en && burst_sel) begin
            rt = "R5 random tx"; rr = "R7 random rx";
         end else if (!q_en) begin
            rt = "R8 random tx"; rr = "R8 random rx";
         end else begin
            rt = "R3 random tx"; rr = "R4 random rx";
         end
         step(rt, rr);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule